// File: doc/BRIEF.md
# DRAM Column Command Timing Tracker

This block holds, for each bank of each rank on one memory channel, two earliest-allowed cycle times: one for the next read column command and one for the next write column command. A scheduler presents a candidate burst (direction, rank, bank) together with the current cycle count. The block answers at once with the cycle in which that burst would issue and the cycle in which its data would be ready. When the scheduler fires the burst, the block stores the issue time plus one burst length as the start of the next allowed burst. It also pushes forward both limits of every bank.

How far each limit moves depends on three things: where the bank sits relative to the target (other rank, same bank group, or other bank group of the same rank), the direction of the issued burst, and the direction of the command the limit guards. An activate raises the limits of one bank to cover the row-to-column delay. A wake-up from power-down raises the limits of every bank of a rank to cover the exit delay. Limits only ever move later. All timing values are static inputs counted in clock cycles, and all times are unsigned cycle counts that saturate at their maximum.

A query port returns the stored read and write limit of any bank. A configuration flag reports an invalid setting.

Top module: `colcmd_timer`

## Requirements
- R1: After reset every bank's read limit, write limit and the next-burst time are 0. The read and the write limit of a bank are stored and reported separately on `q_rd_at` / `q_wr_at`.
- R2: `iss_at` equals the largest of three values: the target bank's limit for the requested direction (`iss_wr`=1 means write), `nxt_burst`, and `now`.
- R3: When `iss_vld` is high at a clock edge, `nxt_burst` becomes `iss_at + t_burst` after that edge. `ready_at` always equals `iss_at + t_cl + t_burst`.
- R4: Same rank, same bank group (group = bank index / (banks per rank / groups per rank)), after issue time T:
  - After a read: read limit T+t_ccd_l, write limit T+max(t_ccd_l, t_rtw+t_burst).
  - After a write: read limit T+max(t_ccd_l, t_cl+t_burst+t_wtr), write limit T+t_ccd_l_wr.
- R5: Same rank, other bank group (or a single group per rank), after issue time T:
  - After a read: read limit T+t_burst, write limit T+t_rtw+t_burst.
  - After a write: read limit T+t_cl+t_burst+t_wtr, write limit T+t_burst.
- R6: For every bank of another rank, both limits become T+t_cs+t_burst, whatever the directions.
- R7: Every update keeps the larger of the new value and the stored one, so no limit ever decreases.
- R8: An activate at time A raises both limits of the addressed bank only to at least A+t_rcd.
- R9: A wake-up at time W with exit delay X raises both limits of every bank in the addressed rank to at least W+X, and leaves other ranks untouched.
- R10: `cfg_bad` is 1 exactly when more than one bank group per rank is configured and t_ccd_l_wr <= t_burst.
- R11: An issue and an activate in the same cycle are both applied: each bank keeps the largest of its stored limit, the issue-driven value and the activate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now | input | TW | Current cycle count |
| t_burst | input | PW | Burst length in cycles |
| t_cl | input | PW | Read latency |
| t_wtr | input | PW | Write-to-read turnaround extra |
| t_rtw | input | PW | Read-to-write turnaround extra |
| t_ccd_l | input | PW | Same-group column-to-column delay |
| t_ccd_l_wr | input | PW | Same-group write-to-write delay |
| t_cs | input | PW | Rank switch gap |
| t_rcd | input | PW | Row-to-column delay |
| iss_vld | input | 1 | Fire the presented burst at this edge |
| iss_wr | input | 1 | Burst direction, 1 = write |
| iss_rank | input | RW | Target rank |
| iss_bank | input | BW | Target bank within the rank |
| iss_at | output | TW | Issue cycle of the presented burst |
| ready_at | output | TW | Data-ready cycle of the presented burst |
| nxt_burst | output | TW | Earliest start of the next burst |
| act_vld | input | 1 | Activate event |
| act_rank | input | RW | Activate rank |
| act_bank | input | BW | Activate bank |
| act_time | input | TW | Activate cycle |
| wake_vld | input | 1 | Wake-up event |
| wake_rank | input | RW | Rank that wakes |
| wake_time | input | TW | Wake-up cycle |
| wake_exit | input | PW | Exit delay |
| q_rank | input | RW | Query rank |
| q_bank | input | BW | Query bank |
| q_rd_at | output | TW | Queried bank's read limit |
| q_wr_at | output | TW | Queried bank's write limit |
| cfg_bad | output | 1 | Invalid timing configuration |

## Verification
A burst issue and an activate can land in the same clock edge, and both write the limit registers. The bench fires a read to one bank while activating its same-group neighbour with a late activate time. The neighbour must end at the activate-driven value, because it is larger than its issue-driven value. The target bank must end at its issue-driven value, and a bank in the other group must show the cross-group read and write offsets, so any loss of either update shows at the query port.

// File: rtl/colt_pkg.sv
package colt_pkg;
   // relation of a bank to the bank targeted by an issued burst
   typedef enum logic [1:0] {
      REL_OTHER_RANK = 2'd0,
      REL_SAME_GRP   = 2'd1,
      REL_DIFF_GRP   = 2'd2
   } colt_rel_e;

   localparam int unsigned COLT_MAX_TW = 30;
endpackage

// File: rtl/colt_delay_sel.sv
// Offsets applied to bank limits after a burst, per relation and guarded direction.
module colt_delay_sel #(
   parameter int unsigned PW = 8,
   parameter int unsigned TW = 16
) (
   input  logic [PW-1:0] t_burst,
   input  logic [PW-1:0] t_cl,
   input  logic [PW-1:0] t_wtr,
   input  logic [PW-1:0] t_rtw,
   input  logic [PW-1:0] t_ccd_l,
   input  logic [PW-1:0] t_ccd_l_wr,
   input  logic [PW-1:0] t_cs,
   input  logic          is_wr,
   output logic [TW-1:0] sg_rd,
   output logic [TW-1:0] sg_wr,
   output logic [TW-1:0] dg_rd,
   output logic [TW-1:0] dg_wr,
   output logic [TW-1:0] or_both
);
   logic [TW-1:0] burst_w, ccd_w, ccdwr_w, w2r_gap, r2w_gap;

   assign burst_w = TW'(t_burst);
   assign ccd_w   = TW'(t_ccd_l);
   assign ccdwr_w = TW'(t_ccd_l_wr);
   assign w2r_gap = TW'(t_cl) + TW'(t_burst) + TW'(t_wtr);
   assign r2w_gap = TW'(t_rtw) + TW'(t_burst);
   assign or_both = TW'(t_cs) + TW'(t_burst);

   always_comb begin
      if (is_wr) begin
         sg_rd = (w2r_gap > ccd_w) ? w2r_gap : ccd_w;
         sg_wr = ccdwr_w;
         dg_rd = w2r_gap;
         dg_wr = burst_w;
      end else begin
         sg_rd = ccd_w;
         sg_wr = (r2w_gap > ccd_w) ? r2w_gap : ccd_w;
         dg_rd = burst_w;
         dg_wr = r2w_gap;
      end
   end
endmodule

// File: rtl/colt_bank_lim.sv
// One bank's read and write limit pair; every source is folded in with a max.
module colt_bank_lim #(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_fire,
   input  logic [TW-1:0] iss_rd_t,
   input  logic [TW-1:0] iss_wr_t,
   input  logic          act_hit,
   input  logic [TW-1:0] act_t,
   input  logic          wake_hit,
   input  logic [TW-1:0] wake_t,
   output logic [TW-1:0] rd_lim,
   output logic [TW-1:0] wr_lim
);
   logic [TW-1:0] rd_nx, wr_nx;

   always_comb begin
      rd_nx = rd_lim;
      wr_nx = wr_lim;
      if (iss_fire && (iss_rd_t > rd_nx)) rd_nx = iss_rd_t;
      if (iss_fire && (iss_wr_t > wr_nx)) wr_nx = iss_wr_t;
      if (act_hit  && (act_t    > rd_nx)) rd_nx = act_t;
      if (act_hit  && (act_t    > wr_nx)) wr_nx = act_t;
      if (wake_hit && (wake_t   > rd_nx)) rd_nx = wake_t;
      if (wake_hit && (wake_t   > wr_nx)) wr_nx = wake_t;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lim <= '0;
         wr_lim <= '0;
      end else begin
         rd_lim <= rd_nx;
         wr_lim <= wr_nx;
      end
   end
endmodule

// File: rtl/colcmd_timer.sv
module colcmd_timer
   import colt_pkg::*;
#(
   parameter int unsigned RANKS           = 2,
   parameter int unsigned BANKS_PER_RANK  = 4,
   parameter int unsigned GROUPS_PER_RANK = 2,
   parameter int unsigned TW              = 16,
   parameter int unsigned PW              = 8,
   localparam int unsigned RW = $clog2(RANKS),
   localparam int unsigned BW = $clog2(BANKS_PER_RANK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] now,
   input  logic [PW-1:0] t_burst,
   input  logic [PW-1:0] t_cl,
   input  logic [PW-1:0] t_wtr,
   input  logic [PW-1:0] t_rtw,
   input  logic [PW-1:0] t_ccd_l,
   input  logic [PW-1:0] t_ccd_l_wr,
   input  logic [PW-1:0] t_cs,
   input  logic [PW-1:0] t_rcd,
   input  logic          iss_vld,
   input  logic          iss_wr,
   input  logic [RW-1:0] iss_rank,
   input  logic [BW-1:0] iss_bank,
   output logic [TW-1:0] iss_at,
   output logic [TW-1:0] ready_at,
   output logic [TW-1:0] nxt_burst,
   input  logic          act_vld,
   input  logic [RW-1:0] act_rank,
   input  logic [BW-1:0] act_bank,
   input  logic [TW-1:0] act_time,
   input  logic          wake_vld,
   input  logic [RW-1:0] wake_rank,
   input  logic [TW-1:0] wake_time,
   input  logic [PW-1:0] wake_exit,
   input  logic [RW-1:0] q_rank,
   input  logic [BW-1:0] q_bank,
   output logic [TW-1:0] q_rd_at,
   output logic [TW-1:0] q_wr_at,
   output logic          cfg_bad
);
   localparam int unsigned NB  = RANKS * BANKS_PER_RANK;
   localparam int unsigned BPG = BANKS_PER_RANK / GROUPS_PER_RANK;
   localparam int unsigned GSH = $clog2(BPG);
   localparam int unsigned IW  = RW + BW;

   // elaboration-time parameter checks
   if (RANKS < 2 || (1 << RW) != RANKS) begin : g_chk_ranks
      $error("RANKS must be a power of two, at least 2");
   end
   if (BANKS_PER_RANK < 2 || (1 << BW) != BANKS_PER_RANK) begin : g_chk_banks
      $error("BANKS_PER_RANK must be a power of two, at least 2");
   end
   if (GROUPS_PER_RANK < 1 || BPG * GROUPS_PER_RANK != BANKS_PER_RANK ||
       (1 << GSH) != BPG) begin : g_chk_groups
      $error("GROUPS_PER_RANK must divide BANKS_PER_RANK into power-of-two groups");
   end
   if (TW > COLT_MAX_TW || TW < PW + 3) begin : g_chk_tw
      $error("TW must lie between PW+3 and COLT_MAX_TW");
   end

   function automatic logic [TW-1:0] sat_add(input logic [TW-1:0] a,
                                             input logic [TW-1:0] b);
      logic [TW:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[TW] ? {TW{1'b1}} : s[TW-1:0];
   endfunction

   logic [TW-1:0] rd_arr [NB];
   logic [TW-1:0] wr_arr [NB];
   logic [NB*TW-1:0] rd_flat, wr_flat;

   logic [IW-1:0] iss_idx, act_idx, q_idx;
   logic [TW-1:0] sel_lim, nb_q;
   logic [TW-1:0] sg_rd, sg_wr, dg_rd, dg_wr, or_both;
   logic [TW-1:0] t_sg_rd, t_sg_wr, t_dg_rd, t_dg_wr, t_or;
   logic [TW-1:0] act_tgt, wake_tgt;

   assign iss_idx = {iss_rank, iss_bank};
   assign act_idx = {act_rank, act_bank};
   assign q_idx   = {q_rank, q_bank};

   // issue time: bank limit for the direction, next-burst time, current time
   always_comb begin
      sel_lim = iss_wr ? wr_arr[iss_idx] : rd_arr[iss_idx];
      iss_at  = sel_lim;
      if (nb_q > iss_at) iss_at = nb_q;
      if (now  > iss_at) iss_at = now;
   end

   assign ready_at  = sat_add(iss_at, TW'(t_cl) + TW'(t_burst));
   assign nxt_burst = nb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       nb_q <= '0;
      else if (iss_vld) nb_q <= sat_add(iss_at, TW'(t_burst));
   end

   colt_delay_sel #(.PW(PW), .TW(TW)) u_dly (
      .t_burst(t_burst), .t_cl(t_cl), .t_wtr(t_wtr), .t_rtw(t_rtw),
      .t_ccd_l(t_ccd_l), .t_ccd_l_wr(t_ccd_l_wr), .t_cs(t_cs),
      .is_wr(iss_wr),
      .sg_rd(sg_rd), .sg_wr(sg_wr), .dg_rd(dg_rd), .dg_wr(dg_wr),
      .or_both(or_both)
   );

   assign t_sg_rd  = sat_add(iss_at, sg_rd);
   assign t_sg_wr  = sat_add(iss_at, sg_wr);
   assign t_dg_rd  = sat_add(iss_at, dg_rd);
   assign t_dg_wr  = sat_add(iss_at, dg_wr);
   assign t_or     = sat_add(iss_at, or_both);
   assign act_tgt  = sat_add(act_time, TW'(t_rcd));
   assign wake_tgt = sat_add(wake_time, TW'(wake_exit));

   // bank-group variant: with one group per rank every same-rank bank is "other group"
   logic same_grp_hit [NB];
   if (GROUPS_PER_RANK > 1) begin : g_grp
      logic [BW-1:0] iss_grp;
      assign iss_grp = iss_bank >> GSH;
      for (genvar i = 0; i < NB; i++) begin : g_cmp
         localparam int unsigned BK = i % BANKS_PER_RANK;
         assign same_grp_hit[i] = (iss_grp == BW'(BK / BPG));
      end
      assign cfg_bad = (t_ccd_l_wr <= t_burst);
   end else begin : g_nogrp
      for (genvar i = 0; i < NB; i++) begin : g_cmp
         assign same_grp_hit[i] = 1'b0;
      end
      assign cfg_bad = 1'b0;
   end

   for (genvar i = 0; i < NB; i++) begin : g_bank
      localparam int unsigned RK = i / BANKS_PER_RANK;
      colt_rel_e     rel;
      logic [TW-1:0] up_rd, up_wr;

      always_comb begin
         if (iss_rank != RW'(RK))  rel = REL_OTHER_RANK;
         else if (same_grp_hit[i]) rel = REL_SAME_GRP;
         else                      rel = REL_DIFF_GRP;
         unique case (rel)
            REL_SAME_GRP: begin up_rd = t_sg_rd; up_wr = t_sg_wr; end
            REL_DIFF_GRP: begin up_rd = t_dg_rd; up_wr = t_dg_wr; end
            default:      begin up_rd = t_or;    up_wr = t_or;    end
         endcase
      end

      colt_bank_lim #(.TW(TW)) u_lim (
         .clk(clk), .rst_n(rst_n),
         .iss_fire(iss_vld), .iss_rd_t(up_rd), .iss_wr_t(up_wr),
         .act_hit(act_vld && (act_idx == IW'(i))), .act_t(act_tgt),
         .wake_hit(wake_vld && (wake_rank == RW'(RK))), .wake_t(wake_tgt),
         .rd_lim(rd_arr[i]), .wr_lim(wr_arr[i])
      );

      assign rd_flat[i*TW +: TW] = rd_arr[i];
      assign wr_flat[i*TW +: TW] = wr_arr[i];
   end

   assign q_rd_at = rd_arr[q_idx];
   assign q_wr_at = wr_arr[q_idx];
endmodule

// File: rtl/colt_chk.sv
module colt_chk #(
   parameter int unsigned NB  = 8,
   parameter int unsigned TW  = 16,
   parameter int unsigned PW  = 8,
   parameter int unsigned IW  = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iss_vld,
   input logic [TW-1:0] iss_at,
   input logic [TW-1:0] nxt_burst,
   input logic [TW-1:0] now,
   input logic [PW-1:0] t_burst,
   input logic [PW-1:0] t_rcd,
   input logic          act_vld,
   input logic [IW-1:0] act_idx,
   input logic [TW-1:0] act_time,
   input logic [NB*TW-1:0] rd_flat,
   input logic [NB*TW-1:0] wr_flat
);
   localparam logic [TW-1:0] SAFE = TW'((1 << TW) - (1 << (PW + 2)));

   // R2
   iss_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld |-> (iss_at >= nxt_burst) && (iss_at >= now));

   // R3
   nxt_burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && (iss_at <= SAFE)) |=>
         (nxt_burst == $past(iss_at) + TW'($past(t_burst))));

   for (genvar i = 0; i < NB; i++) begin : g_b
      // R7
      rd_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_flat[i*TW +: TW] >= $past(rd_flat[i*TW +: TW]));
      // R7
      wr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_flat[i*TW +: TW] >= $past(wr_flat[i*TW +: TW]));
      // R8
      act_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_vld && (act_idx == IW'(i)) && (act_time <= SAFE)) |=>
            (rd_flat[i*TW +: TW] >= $past(act_time) + TW'($past(t_rcd))) &&
            (wr_flat[i*TW +: TW] >= $past(act_time) + TW'($past(t_rcd))));
   end
endmodule

bind colcmd_timer colt_chk #(.NB(NB), .TW(TW), .PW(PW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_at(iss_at),
   .nxt_burst(nxt_burst), .now(now), .t_burst(t_burst), .t_rcd(t_rcd),
   .act_vld(act_vld), .act_idx(act_idx), .act_time(act_time),
   .rd_flat(rd_flat), .wr_flat(wr_flat)
);

// File: tb/sim_colcmd_timer.sv
`timescale 1ns/1ps
module sim_colcmd_timer;
   localparam int TW = 16;
   localparam int PW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TW-1:0] now = '0;
   logic [PW-1:0] t_burst = 8'd4, t_cl = 8'd10, t_wtr = 8'd6, t_rtw = 8'd1;
   logic [PW-1:0] t_ccd_l = 8'd6, t_ccd_l_wr = 8'd8, t_cs = 8'd2, t_rcd = 8'd5;
   logic iss_vld = 1'b0, iss_wr = 1'b0;
   logic [0:0] iss_rank = '0;
   logic [1:0] iss_bank = '0;
   logic [TW-1:0] iss_at, ready_at, nxt_burst;
   logic act_vld = 1'b0;
   logic [0:0] act_rank = '0;
   logic [1:0] act_bank = '0;
   logic [TW-1:0] act_time = '0;
   logic wake_vld = 1'b0;
   logic [0:0] wake_rank = '0;
   logic [TW-1:0] wake_time = '0;
   logic [PW-1:0] wake_exit = '0;
   logic [0:0] q_rank = '0;
   logic [1:0] q_bank = '0;
   logic [TW-1:0] q_rd_at, q_wr_at;
   logic cfg_bad;

   always #4 clk = ~clk;

   colcmd_timer u0 (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic query(input int r, input int b, input int erd, input int ewr,
                        input string tag);
      q_rank = 1'(r); q_bank = 2'(b);
      #1;
      chk(32'(q_rd_at), erd, {tag, " rd"});
      chk(32'(q_wr_at), ewr, {tag, " wr"});
   endtask

   // entry: {wr, rank, bank[1:0], now[15:0], expected issue[15:0]}
   localparam logic [35:0] VEC [7] = '{
      {1'b0, 1'b0, 2'd0, 16'd0,  16'd0},
      {1'b0, 1'b0, 2'd2, 16'd0,  16'd4},
      {1'b1, 1'b0, 2'd1, 16'd0,  16'd9},
      {1'b1, 1'b0, 2'd3, 16'd0,  16'd13},
      {1'b0, 1'b1, 2'd0, 16'd0,  16'd19},
      {1'b0, 1'b1, 2'd2, 16'd40, 16'd40},
      {1'b1, 1'b0, 2'd0, 16'd40, 16'd46}
   };

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      query(0, 0, 0, 0, "R1 reset r0b0");
      query(1, 3, 0, 0, "R1 reset r1b3");
      chk(32'(nxt_burst), 0, "R1 reset nxt_burst");
      rst_n = 1'b1;
      @(negedge clk);
      // R10 configuration flag
      chk(32'(cfg_bad), 0, "R10 valid config");
      t_ccd_l_wr = 8'd4; #1;
      chk(32'(cfg_bad), 1, "R10 ccd_l_wr equal burst");
      t_ccd_l_wr = 8'd5; #1;
      chk(32'(cfg_bad), 0, "R10 ccd_l_wr above burst");
      t_ccd_l_wr = 8'd8;

      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         iss_wr   = VEC[k][35];
         iss_rank = VEC[k][34];
         iss_bank = VEC[k][33:32];
         now      = VEC[k][31:16];
         #1;
         chk(32'(iss_at), 32'(VEC[k][15:0]), $sformatf("R2 vec%0d iss_at", k));
         chk(32'(ready_at), 32'(VEC[k][15:0]) + 14, $sformatf("R3 vec%0d ready_at", k));
         iss_vld = 1'b1;
         @(negedge clk);
         iss_vld = 1'b0;
         chk(32'(nxt_burst), 32'(VEC[k][15:0]) + 4, $sformatf("R3 vec%0d nxt_burst", k));
         if (k == 0) begin
            query(0, 1, 6, 6, "R4 rd same group");
            query(0, 2, 4, 5, "R5 rd other group");
            query(1, 3, 6, 6, "R6 other rank");
         end
         if (k == 4) query(0, 0, 33, 25, "R7 keep later limit");
      end
      now = '0;
      query(0, 1, 66, 54, "R4 wr same group / R1 separate");
      query(0, 3, 66, 50, "R5 wr other group");
      query(1, 3, 52, 52, "R6 wr other rank");

      // R8 activate
      @(negedge clk);
      act_vld = 1'b1; act_rank = 1'b1; act_bank = 2'd1; act_time = 16'd60;
      @(negedge clk);
      act_vld = 1'b0;
      query(1, 1, 65, 65, "R8 activate bank");
      query(1, 0, 52, 52, "R8 neighbour untouched");
      act_vld = 1'b1; act_time = 16'd0;
      @(negedge clk);
      act_vld = 1'b0;
      query(1, 1, 65, 65, "R7 early activate ignored");

      // R9 wake-up
      wake_vld = 1'b1; wake_rank = 1'b0; wake_time = 16'd100; wake_exit = 8'd7;
      @(negedge clk);
      wake_vld = 1'b0;
      query(0, 2, 107, 107, "R9 wake rank0");
      query(1, 1, 65, 65, "R9 other rank untouched");

      // R11 issue and activate in one cycle
      iss_wr = 1'b0; iss_rank = 1'b1; iss_bank = 2'd3; now = '0;
      act_rank = 1'b1; act_bank = 2'd2; act_time = 16'd80;
      #1;
      chk(32'(iss_at), 52, "R11 issue time");
      iss_vld = 1'b1; act_vld = 1'b1;
      @(negedge clk);
      iss_vld = 1'b0; act_vld = 1'b0;
      chk(32'(nxt_burst), 56, "R11 nxt_burst");
      query(1, 2, 85, 85, "R11 activate wins");
      query(1, 3, 58, 58, "R11 issue target");
      query(1, 0, 56, 57, "R11 other group");
      query(0, 2, 107, 107, "R11 other rank kept");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule